// File: doc/BRIEF.md
# Temperature Window Indexer

The block turns a stream of signed temperature samples into a 6-bit pointer that selects one of 36 entries in a downstream lookup table. Each table entry stands for a four-degree band. The lowest entry also absorbs everything colder than its band, and the highest absorbs everything hotter. A new sample arrives with a one-cycle strobe once per conversion frame, typically every 16 ms. The pointer is registered and changes in the clock cycle after the strobe.

Band changes are asymmetric, so that a reading sitting on a band edge does not make the pointer toggle. A rising reading moves the pointer up as soon as it reaches the even lower edge of a higher band. A falling reading moves it down only once it is `HYST_DEG` degrees below the lower edge of the current band. With the default of one degree, the falling point is the odd value just under that edge. The first sample after reset loads the pointer directly. A freeze input stops automatic updates. While frozen, a host write port may load the pointer directly, and an out-of-range value is saturated to the top entry.

Control is a three-state machine:
- EMPTY: the state after reset, before any pointer has been computed.
- TRACK: automatic updates are running.
- HELD: automatic updates are frozen.

The transitions are:
- first-sample: EMPTY to TRACK, taken by a strobe while not frozen.
- early-write: EMPTY to HELD, taken by a host write while frozen.
- freeze: TRACK to HELD, taken whenever the freeze input is high.
- release: HELD to TRACK, taken when the freeze input drops.
- EMPTY stays put when frozen without a write. TRACK and HELD loop on themselves otherwise.

Top module: `temp_window_indexer`

## Requirements
- R1: After reset the pointer output is 0.
- R2: The first strobed sample after reset, with freeze low, loads clamp(floor((T+40)/4), 0, 35) directly, visible the cycle after the strobe.
- R3: The input is 8-bit two's complement at 1 degree per bit (bit 7 is the sign). Entry 0 covers T <= -37, entry 1 covers -36..-33, entry 34 covers 96..99 and entry 35 covers T >= 100.
- R4: A rising sample whose nominal entry is above the pointer loads that nominal entry, e.g. 28 gives 17 from 16. This may skip several entries in one step.
- R5: The pointer falls only when the sample is at or below (lower edge of the current entry − HYST_DEG). With the default of 1, a sample of 27 takes 17 to 16. With HYST_DEG = 2, 27 holds 17 and 26 gives 16.
- R6: The pointer never exceeds 35 and never goes below 0, for any sample from -128 to 127.
- R7: Without a strobe or an accepted host write, the pointer holds.
- R8: While the freeze input is high, strobed samples are ignored and the pointer holds.
- R9: While the freeze input is high, a host write loads the written value in the next cycle. A value above 35 is saturated to 35.
- R10: A host write with the freeze input low is ignored.
- R11: When a strobe and a host write fall in the same cycle, the host write wins if freeze is high and the sample wins if freeze is low.
- R12: After freeze is released, the next sample applies the hysteresis rule of R4 and R5 starting from the held or host-written pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_i | input | 8 | Signed temperature sample, 1 degree per LSB |
| temp_vld_i | input | 1 | One-cycle strobe marking a new sample |
| auto_dis_i | input | 1 | Freeze: high stops automatic updates and enables host writes |
| host_wr_i | input | 1 | Host write strobe for the pointer |
| host_idx_i | input | 6 | Host write value |
| idx_o | output | 6 | Registered table pointer, 0 to 35 |

## Verification
The host write and the sample strobe can arrive in the same cycle, and the freeze level decides which one owns that cycle. The bench drives both strobes on one falling edge, once with freeze high and a sample of 100 beside a write of 20, and once with freeze low and a sample of 28 beside a write of 3. It judges the result by the pointer one cycle later: 20 in the first case and 17 in the second. A second instance with a two-degree band runs the same stimulus. This shows that after a release, the resumed tracking starts from the host-written pointer rather than from the nominal entry.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_TRACK = 2'd1,
        ST_HELD  = 2'd2
    } twi_state_e;

endpackage

// File: rtl/twi_window_map.sv
// Maps a signed sample, shifted by BIAS degrees, onto a clamped window number.
module twi_window_map #(
    parameter int TEMP_W  = 8,
    parameter int IDX_W   = 6,
    parameter int NUM_WIN = 36,
    parameter int WIN_DEG = 4,
    parameter int OFFSET  = 40,
    parameter int BIAS    = 0
) (
    input  logic [TEMP_W-1:0] temp_i,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int SW = TEMP_W + 8;
    localparam logic signed [SW-1:0] SHIFT = SW'(OFFSET + BIAS);
    localparam logic signed [SW-1:0] DIV   = SW'(WIN_DEG);
    localparam logic signed [SW-1:0] TOP   = SW'(NUM_WIN - 1);

    logic signed [SW-1:0] shifted;
    logic signed [SW-1:0] quot;

    always_comb begin
        shifted = $signed({{(SW-TEMP_W){temp_i[TEMP_W-1]}}, temp_i}) + SHIFT;
        quot    = shifted / DIV;
        if (shifted < 0) begin
            idx_o = '0;
        end else if (quot > TOP) begin
            idx_o = TOP[IDX_W-1:0];
        end else begin
            idx_o = quot[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/twi_hyst_step.sv
// Chooses the next pointer from the current one and the rise / fall candidates.
module twi_hyst_step #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] cur_i,
    input  logic [IDX_W-1:0] rise_i,
    input  logic [IDX_W-1:0] fall_i,
    output logic [IDX_W-1:0] next_o
);

    always_comb begin
        if (rise_i > cur_i) begin
            next_o = rise_i;
        end else if (fall_i < cur_i) begin
            next_o = fall_i;
        end else begin
            next_o = cur_i;
        end
    end

endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
    import twi_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int NUM_WIN = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             temp_vld_i,
    input  logic             auto_dis_i,
    input  logic             host_wr_i,
    input  logic [IDX_W-1:0] host_idx_i,
    input  logic [IDX_W-1:0] seed_idx_i,
    input  logic [IDX_W-1:0] hyst_idx_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_WIN - 1);

    twi_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] host_sat;

    assign host_sat = (host_idx_i > IDX_MAX) ? IDX_MAX : host_idx_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (auto_dis_i && host_wr_i) begin
                    state_d = ST_HELD;
                end else if (!auto_dis_i && temp_vld_i) begin
                    state_d = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (auto_dis_i) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!auto_dis_i) begin
                    state_d = ST_TRACK;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // output pointer
    always_comb begin
        idx_d = idx_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (auto_dis_i && host_wr_i) begin
                    idx_d = host_sat;
                end else if (!auto_dis_i && temp_vld_i) begin
                    idx_d = seed_idx_i;
                end
            end
            ST_TRACK, ST_HELD: begin
                if (auto_dis_i) begin
                    if (host_wr_i) begin
                        idx_d = host_sat;
                    end
                end else if (temp_vld_i) begin
                    idx_d = hyst_idx_i;
                end
            end
            default: idx_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o = idx_q;

    // R6: pointer stays inside the table
    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_MAX);

    // R7: nothing strobed, nothing changes
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_vld_i && !host_wr_i) |=> $stable(idx_q));

    // R8: frozen without a write holds the pointer
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dis_i && !host_wr_i) |=> $stable(idx_q));

    // R8: freeze never leaves the machine tracking
    p_freeze_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_dis_i |=> (state_q != ST_TRACK));

    // R9: oversize host value saturates
    p_host_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dis_i && host_wr_i && host_idx_i > IDX_MAX) |=> (idx_q == IDX_MAX));

    // R2: first sample loads the nominal window
    p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && temp_vld_i && !auto_dis_i)
            |=> (idx_q == $past(seed_idx_i)));

    // R4: a higher nominal window is taken at once while tracking
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && temp_vld_i && !auto_dis_i && seed_idx_i > idx_q)
            |=> (idx_q == $past(seed_idx_i)));

endmodule

// File: rtl/temp_window_indexer.sv
module temp_window_indexer #(
    parameter int TEMP_W   = 8,
    parameter int NUM_WIN  = 36,
    parameter int WIN_DEG  = 4,
    parameter int OFFSET   = 40,
    parameter int HYST_DEG = 1,
    parameter int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_vld_i,
    input  logic              auto_dis_i,
    input  logic              host_wr_i,
    input  logic [IDX_W-1:0]  host_idx_i,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int FALL_BIAS = HYST_DEG - 1;

    logic [IDX_W-1:0] rise_idx;
    logic [IDX_W-1:0] fall_idx;
    logic [IDX_W-1:0] hyst_idx;
    logic [IDX_W-1:0] cur_idx;

    twi_window_map #(
        .TEMP_W (TEMP_W), .IDX_W (IDX_W), .NUM_WIN (NUM_WIN),
        .WIN_DEG(WIN_DEG), .OFFSET(OFFSET), .BIAS(0)
    ) u_rise_map (
        .temp_i (temp_i),
        .idx_o  (rise_idx)
    );

    generate
        if (FALL_BIAS == 0) begin : g_narrow
            assign fall_idx = rise_idx;
        end else begin : g_wide
            twi_window_map #(
                .TEMP_W (TEMP_W), .IDX_W (IDX_W), .NUM_WIN (NUM_WIN),
                .WIN_DEG(WIN_DEG), .OFFSET(OFFSET), .BIAS(FALL_BIAS)
            ) u_fall_map (
                .temp_i (temp_i),
                .idx_o  (fall_idx)
            );
        end
    endgenerate

    twi_hyst_step #(.IDX_W(IDX_W)) u_step (
        .cur_i  (cur_idx),
        .rise_i (rise_idx),
        .fall_i (fall_idx),
        .next_o (hyst_idx)
    );

    twi_ctrl #(.IDX_W(IDX_W), .NUM_WIN(NUM_WIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_vld_i (temp_vld_i),
        .auto_dis_i (auto_dis_i),
        .host_wr_i  (host_wr_i),
        .host_idx_i (host_idx_i),
        .seed_idx_i (rise_idx),
        .hyst_idx_i (hyst_idx),
        .idx_o      (cur_idx)
    );

    assign idx_o = cur_idx;

    // R5: the pointer never falls while the fall candidate is not below it
    p_fall_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld_i && !auto_dis_i && !host_wr_i && fall_idx >= cur_idx
         && rise_idx <= cur_idx) |=> (idx_o == $past(cur_idx)));

endmodule

// File: tb/test_temp_window_indexer.sv
`timescale 1ns/1ps
module test_temp_window_indexer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp = '0;
    logic       vld = 1'b0;
    logic       frz = 1'b0;
    logic       hwr = 1'b0;
    logic [5:0] hidx = '0;
    logic [5:0] idx_n;
    logic [5:0] idx_w;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_w  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    temp_window_indexer i_temp_window_indexer (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .temp_vld_i(vld),
        .auto_dis_i(frz), .host_wr_i(hwr), .host_idx_i(hidx), .idx_o(idx_n)
    );

    temp_window_indexer #(.HYST_DEG(2)) i_temp_window_indexer_wide (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .temp_vld_i(vld),
        .auto_dis_i(frz), .host_wr_i(hwr), .host_idx_i(hidx), .idx_o(idx_w)
    );

    localparam int VEC_N = 18;
    localparam int VT[VEC_N] = '{27, 28, 27, 26, 31, -128, -37, -36, -33,
                                 -32, 0, -1, 96, 99, 100, 127, 99, 98};
    localparam int VE[VEC_N] = '{16, 17, 16, 16, 17, 0, 0, 1, 1,
                                 2, 10, 9, 34, 34, 35, 35, 34, 34};

    function automatic int nominal(int t, int bias);
        int s;
        s = t + 40 + bias;
        if (s < 0) return 0;
        if (s / 4 > 35) return 35;
        return s / 4;
    endfunction

    // two-degree band model (R4, R5)
    function automatic int wide_next(int cur, int t);
        int up, dn;
        up = nominal(t, 0);
        dn = nominal(t, 1);
        if (up > cur) return up;
        if (dn < cur) return dn;
        return cur;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sample(int t, bit w, int h);
        @(negedge clk);
        temp = 8'(t);
        vld  = 1'b1;
        hwr  = w;
        hidx = 6'(h);
        @(negedge clk);
        vld  = 1'b0;
        hwr  = 1'b0;
    endtask

    task automatic host_write(int h);
        @(negedge clk);
        hwr  = 1'b1;
        hidx = 6'(h);
        @(negedge clk);
        hwr  = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset narrow", int'(idx_n), 0);
        chk("R1 reset wide", int'(idx_w), 0);

        // R7: sample value moves without a strobe
        temp = 8'd100;
        repeat (3) @(negedge clk);
        chk("R7 no strobe", int'(idx_n), 0);

        // table walk: R2 first entry, R3 R4 R5 R6 afterwards
        for (int i = 0; i < VEC_N; i++) begin
            sample(VT[i], 1'b0, 0);
            exp_w = wide_next(exp_w, VT[i]);
            chk((i == 0) ? "R2 first sample" : "R3 R4 R5 R6 table narrow",
                int'(idx_n), VE[i]);
            chk("R5 table wide", int'(idx_w), exp_w);
        end

        // R8: frozen sample ignored
        @(negedge clk);
        frz = 1'b1;
        sample(100, 1'b0, 0);
        chk("R8 frozen sample", int'(idx_n), 34);
        chk("R8 frozen sample wide", int'(idx_w), 34);

        // R9: host writes, saturation
        host_write(50);
        chk("R9 saturate", int'(idx_n), 35);
        host_write(5);
        chk("R9 host load", int'(idx_n), 5);
        chk("R9 host load wide", int'(idx_w), 5);

        // R11: same-cycle, freeze high -> write wins
        sample(100, 1'b1, 20);
        chk("R11 write wins", int'(idx_n), 20);

        // R11: same-cycle, freeze low -> sample wins
        @(negedge clk);
        frz = 1'b0;
        sample(28, 1'b1, 3);
        chk("R11 sample wins", int'(idx_n), 17);
        chk("R11 sample wins wide", int'(idx_w), 17);

        // R10: unfrozen write ignored
        host_write(3);
        chk("R10 write ignored", int'(idx_n), 17);

        // R12: resume from a host-written pointer
        @(negedge clk);
        frz = 1'b1;
        host_write(20);
        @(negedge clk);
        frz = 1'b0;
        sample(27, 1'b0, 0);
        chk("R12 resume narrow", int'(idx_n), 16);
        chk("R12 resume wide holds", int'(idx_w), wide_next(20, 27));
        sample(26, 1'b0, 0);
        chk("R12 resume wide falls", int'(idx_w), wide_next(wide_next(20, 27), 26));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule